// File: doc/BRIEF.md
# Int8 Paired-Tile Matrix Multiply-Accumulate Engine

This engine computes C += A×B over signed 8-bit operand tiles and produces an 8x8 block of results. Each K-step loads two 4x16 A tiles that sit one above the other in the same tile column, followed by one 16x8 B tile that both of them share. The two resulting 4x8 C tiles are vertically adjacent and together form one 8x8 super-tile. Sharing one B tile between two A tiles means the four B beats serve twice the compute they otherwise would. Each K-step carries 1024 multiply-accumulates, and the datapath processes 256 of them per cycle.

A `start` pulse clears the 32-bit accumulators and samples two settings: the accumulation depth `k_steps` and the output width `out_wide`. The engine then repeats a cycle of load followed by compute until it has run `k_steps` K-steps. After that it streams the super-tile out in one of two forms: as 32-bit elements, or as 16-bit elements that saturate. Both data ports use valid/ready. A beat moves only in a cycle where valid and ready are both high. The engine raises `ld_ready` only while it is waiting for an operand beat, and it simply waits when `ld_valid` is low. It holds `st_valid` and `st_data` unchanged for as long as `st_ready` stays low.

Top module: `mm_tile_engine`

## Requirements
- R1: After reset, `ld_ready`, `st_valid` and `done` are low, and they stay low until `start` arrives.
- R2: A `start` in idle samples `k_steps` and `out_wide`, clears all accumulators, and raises `ld_ready` in the next cycle. Each K-step then accepts 8 load beats. Beats 0-3 carry super-tile rows 0-7 of A, two rows per beat (beat j holds rows 2j and 2j+1). Beats 4-7 carry B.
- R3: The bytes are signed. In A beat j, row 2j+r (r = 0 or 1) and column k sit at bits [(16r+k)*8 +: 8]. In B beat 4+b, row 4b+q and column n sit at bits [(8q+n)*8 +: 8].
- R4: After the eighth load beat of a K-step is accepted, `ld_ready` stays low for exactly 4 compute cycles.
- R5: Products accumulate over `k_steps` K-steps before the store begins, and a value of 0 counts as 1. Accumulators are 32 bits wide and wrap on overflow.
- R6: With `out_wide`=1, the store sends 8 beats. Beat j carries super-tile row j, with column n at bits [32n +: 32].
- R7: With `out_wide`=0, the store sends 4 beats. Beat j carries rows 2j+r, with element n at bits [(8r+n)*16 +: 16], each value saturated to the range -32768..32767.
- R8: While `st_valid` is high and `st_ready` is low, `st_valid` stays high and `st_data` does not change. No load beat is accepted while `ld_valid` is low.
- R9: `done` pulses high for exactly one cycle, in the cycle after the last store beat is accepted. The engine is idle from that cycle on.
- R10: A `start` that arrives while the engine is busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new super-tile; acted on only when idle |
| k_steps | input | 8 | Number of K-steps to accumulate (0 counts as 1) |
| out_wide | input | 1 | 1: 32-bit results, 0: saturated 16-bit results |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Engine can take a load beat |
| ld_data | input | 256 | Load beat payload |
| st_valid | output | 1 | Store beat valid |
| st_ready | input | 1 | Consumer takes the store beat |
| st_data | output | 256 | Store beat payload |
| done | output | 1 | One-cycle pulse after the final store beat |

## Verification
If a beat counter slips or a buffer slot is written out of turn, the handshake timing at the ports shifts at once. `ld_ready` or `st_valid` then opens or closes a cycle too early or too late, and the per-cycle comparison catches it in that same cycle. A mis-decoded operand byte, a lost partial sum, or a wrong saturation limit does not appear until the first store beat of the super-tile. Because every store beat is compared in full, an error of this kind is still pinned to the row it corrupts. A `start` that is wrongly taken mid-run changes either the number of K-steps or the store length, and the next change of phase exposes it.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_COMP  = 2'd2,
    PH_STORE = 2'd3
  } phase_t;
endpackage

// File: rtl/mm_dot_row.sv
// One output row: a 1xKDIM signed vector times a KDIMxNCOL signed tile.
module mm_dot_row #(
  parameter int EW   = 8,
  parameter int KDIM = 16,
  parameter int NCOL = 8,
  parameter int PW   = 32
) (
  input  logic [KDIM*EW-1:0]      a_row,
  input  logic [KDIM*NCOL*EW-1:0] b_tile,
  output logic [NCOL*PW-1:0]      sums
);
  always_comb begin
    logic signed [PW-1:0] t;
    logic signed [PW-1:0] pa;
    logic signed [PW-1:0] pb;
    sums = '0;
    for (int n = 0; n < NCOL; n++) begin
      t = '0;
      for (int k = 0; k < KDIM; k++) begin
        pa = PW'($signed(a_row[k*EW +: EW]));
        pb = PW'($signed(b_tile[(k*NCOL+n)*EW +: EW]));
        t  = t + pa * pb;
      end
      sums[n*PW +: PW] = t;
    end
  end
endmodule

// File: rtl/mm_operand_buf.sv
// Holds every load beat of one K-step; slot index equals beat order.
module mm_operand_buf #(
  parameter int BUSW   = 256,
  parameter int NBEATS = 8,
  parameter int IW     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [BUSW-1:0]        wr_data,
  output logic [NBEATS*BUSW-1:0] beats
);
  for (genvar s = 0; s < NBEATS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        beats[s*BUSW +: BUSW] <= '0;
      else if (wr_en && (wr_idx == IW'(s)))
        beats[s*BUSW +: BUSW] <= wr_data;
    end
  end
endmodule

// File: rtl/mm_store_fmt.sv
// Picks one store beat out of the accumulator block, with 16-bit saturation.
module mm_store_fmt #(
  parameter int BUSW  = 256,
  parameter int SROWS = 8,
  parameter int NCOL  = 8,
  parameter int ACCW  = 32,
  parameter int OW    = 16,
  parameter int IW    = 3
) (
  input  logic [SROWS*NCOL*ACCW-1:0] acc_flat,
  input  logic                       wide,
  input  logic [IW-1:0]              beat,
  output logic [BUSW-1:0]            data
);
  localparam int RPB_W = BUSW / (NCOL*ACCW);
  localparam int RPB_N = BUSW / (NCOL*OW);
  localparam logic signed [ACCW-1:0] SMAX = ACCW'((1 << (OW-1)) - 1);
  localparam logic signed [ACCW-1:0] SMIN = ~SMAX;

  always_comb begin
    logic signed [ACCW-1:0] v;
    data = '0;
    v    = '0;
    if (wide) begin
      for (int r = 0; r < RPB_W; r++)
        for (int n = 0; n < NCOL; n++)
          data[(r*NCOL+n)*ACCW +: ACCW] =
            acc_flat[((int'(beat)*RPB_W + r)*NCOL + n)*ACCW +: ACCW];
    end else begin
      for (int r = 0; r < RPB_N; r++)
        for (int n = 0; n < NCOL; n++) begin
          v = acc_flat[((int'(beat)*RPB_N + r)*NCOL + n)*ACCW +: ACCW];
          if (v > SMAX)      data[(r*NCOL+n)*OW +: OW] = SMAX[OW-1:0];
          else if (v < SMIN) data[(r*NCOL+n)*OW +: OW] = SMIN[OW-1:0];
          else               data[(r*NCOL+n)*OW +: OW] = v[OW-1:0];
        end
    end
  end
endmodule

// File: rtl/mm_tile_engine.sv
module mm_tile_engine #(
  parameter int BUSW  = 256,
  parameter int EW    = 8,
  parameter int AROWS = 4,
  parameter int KDIM  = 16,
  parameter int NCOL  = 8,
  parameter int ACCW  = 32,
  parameter int OW    = 16,
  parameter int KSW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [KSW-1:0]  k_steps,
  input  logic            out_wide,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [BUSW-1:0] ld_data,
  output logic            st_valid,
  input  logic            st_ready,
  output logic [BUSW-1:0] st_data,
  output logic            done
);
  import mm_pkg::*;

  localparam int SROWS    = 2 * AROWS;
  localparam int ROWW     = KDIM * EW;
  localparam int A_BEATS  = SROWS * ROWW / BUSW;
  localparam int B_BEATS  = KDIM * NCOL * EW / BUSW;
  localparam int LD_BEATS = A_BEATS + B_BEATS;
  localparam int RPC      = BUSW / ROWW;
  localparam int CYCS     = SROWS / RPC;
  localparam int W_BEATS  = SROWS * NCOL * ACCW / BUSW;
  localparam int N_BEATS  = SROWS * NCOL * OW / BUSW;
  localparam int MAXB     = (LD_BEATS > W_BEATS) ? LD_BEATS : W_BEATS;
  localparam int CW       = $clog2(MAXB);
  localparam int CCW      = $clog2(CYCS);
  localparam int RW       = $clog2(SROWS);

  phase_t           state;
  logic [CW-1:0]    cnt;
  logic [KSW-1:0]   kcnt;
  logic [KSW-1:0]   kmax_q;
  logic             wide_q;
  logic [CW-1:0]    last_st;

  logic [ACCW-1:0]  acc_q [SROWS][NCOL];
  logic [SROWS*NCOL*ACCW-1:0] acc_flat;
  logic [LD_BEATS*BUSW-1:0]   beats;
  logic [A_BEATS*BUSW-1:0]    a_flat;
  logic [B_BEATS*BUSW-1:0]    b_flat;
  logic [BUSW-1:0]            a_sel;
  logic [NCOL*ACCW-1:0]       dot_flat [RPC];

  assign ld_ready = (state == PH_LOAD);
  assign st_valid = (state == PH_STORE);
  assign last_st  = wide_q ? CW'(W_BEATS-1) : CW'(N_BEATS-1);

  // ---------------- control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      kcnt   <= '0;
      kmax_q <= KSW'(1);
      wide_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        PH_IDLE: if (start) begin
          state  <= PH_LOAD;
          cnt    <= '0;
          kcnt   <= '0;
          kmax_q <= (k_steps == '0) ? KSW'(1) : k_steps;
          wide_q <= out_wide;
        end
        PH_LOAD: if (ld_valid) begin
          if (cnt == CW'(LD_BEATS-1)) begin
            cnt   <= '0;
            state <= PH_COMP;
          end else cnt <= cnt + CW'(1);
        end
        PH_COMP: begin
          if (cnt == CW'(CYCS-1)) begin
            cnt   <= '0;
            kcnt  <= kcnt + KSW'(1);
            state <= (kcnt == kmax_q - KSW'(1)) ? PH_STORE : PH_LOAD;
          end else cnt <= cnt + CW'(1);
        end
        PH_STORE: if (st_ready) begin
          if (cnt == last_st) begin
            cnt   <= '0;
            state <= PH_IDLE;
            done  <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        default: state <= PH_IDLE;
      endcase
    end
  end

  // ---------------- operands ----------------
  mm_operand_buf #(.BUSW(BUSW), .NBEATS(LD_BEATS), .IW(CW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_ready && ld_valid),
    .wr_idx  (cnt),
    .wr_data (ld_data),
    .beats   (beats)
  );

  assign a_flat = beats[A_BEATS*BUSW-1:0];
  assign b_flat = beats[LD_BEATS*BUSW-1 : A_BEATS*BUSW];
  assign a_sel  = a_flat[int'(cnt[CCW-1:0])*BUSW +: BUSW];

  for (genvar i = 0; i < RPC; i++) begin : g_dot
    mm_dot_row #(.EW(EW), .KDIM(KDIM), .NCOL(NCOL), .PW(ACCW)) u_dot (
      .a_row  (a_sel[i*ROWW +: ROWW]),
      .b_tile (b_flat),
      .sums   (dot_flat[i])
    );
  end

  // ---------------- accumulators ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < SROWS; r++)
        for (int n = 0; n < NCOL; n++)
          acc_q[r][n] <= '0;
    end else if (state == PH_IDLE && start) begin
      for (int r = 0; r < SROWS; r++)
        for (int n = 0; n < NCOL; n++)
          acc_q[r][n] <= '0;
    end else if (state == PH_COMP) begin
      for (int i = 0; i < RPC; i++)
        for (int n = 0; n < NCOL; n++)
          acc_q[RW'(int'(cnt[CCW-1:0])*RPC + i)][n] <=
            acc_q[RW'(int'(cnt[CCW-1:0])*RPC + i)][n] + dot_flat[i][n*ACCW +: ACCW];
    end
  end

  always_comb begin
    for (int r = 0; r < SROWS; r++)
      for (int n = 0; n < NCOL; n++)
        acc_flat[(r*NCOL+n)*ACCW +: ACCW] = acc_q[r][n];
  end

  // ---------------- store ----------------
  mm_store_fmt #(.BUSW(BUSW), .SROWS(SROWS), .NCOL(NCOL), .ACCW(ACCW),
                 .OW(OW), .IW(CW)) u_fmt (
    .acc_flat (acc_flat),
    .wide     (wide_q),
    .beat     (cnt),
    .data     (st_data)
  );

  // ---------------- assertions ----------------
  p_st_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  p_done_after_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_valid && st_ready));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_depth_reached_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_valid) |-> (kcnt == kmax_q));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != PH_IDLE) |=> ($stable(kmax_q) && $stable(wide_q)));

  p_acc_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && $past(st_valid)) |-> $stable(acc_flat));
endmodule

// File: tb/sim_mm_tile_engine.sv
module sim_mm_tile_engine;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, start, out_wide, ld_valid, st_ready;
  logic [7:0]   k_steps;
  logic [255:0] ld_data;
  logic         ld_ready, st_valid, done;
  logic [255:0] st_data;

  mm_tile_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .k_steps(k_steps),
    .out_wide(out_wide), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .done(done)
  );

  int    n_tests = 0, n_fail = 0;
  string tag = "R1";
  bit    checking = 0;

  // behavioural reference state
  int ph = 0, cnt = 0, kc = 0, kmax = 1, tiles_done = 0;
  bit wide_m = 0, exp_done = 0, ld_taken = 0;
  int a_m [8][16];
  int b_m [16][8];
  int acc_m [8][8];

  // stimulus state
  int pat = 0, pend_pat = 0, gen_idx = 0, pend_idx = 0;
  bit hs_full = 1, pending = 0;

  function automatic logic [255:0] gen_beat(int idx, int p);
    logic [255:0] d;
    if (p == 1)      d = {32{8'h7F}};
    else if (p == 2) d = (idx < 4) ? {32{8'h80}} : {32{8'h7F}};
    else             d = {$urandom, $urandom, $urandom, $urandom,
                          $urandom, $urandom, $urandom, $urandom};
    return d;
  endfunction

  function automatic logic [255:0] exp_beat(int j, bit w);
    logic [255:0] d;
    int v;
    d = '0;
    if (w) begin
      for (int n = 0; n < 8; n++) d[n*32 +: 32] = acc_m[j][n];
    end else begin
      for (int r = 0; r < 2; r++)
        for (int n = 0; n < 8; n++) begin
          v = acc_m[2*j+r][n];
          if (v > 32767) v = 32767;
          if (v < -32768) v = -32768;
          d[(r*8+n)*16 +: 16] = v[15:0];
        end
    end
    return d;
  endfunction

  task automatic chk(bit ok, string t, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", t, $time, act, exp);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cnt = 0; kc = 0; exp_done = 0; ld_taken = 0;
    end else begin
      exp_done = 0;
      ld_taken = 0;
      case (ph)
        0: if (start) begin
          ph = 1; cnt = 0; kc = 0;
          kmax = (k_steps == 0) ? 1 : int'(k_steps);
          wide_m = out_wide;
          for (int r = 0; r < 8; r++) for (int n = 0; n < 8; n++) acc_m[r][n] = 0;
        end
        1: if (ld_valid) begin
          if (cnt < 4) begin
            for (int r = 0; r < 2; r++) for (int k = 0; k < 16; k++)
              a_m[2*cnt+r][k] = int'($signed(ld_data[(r*16+k)*8 +: 8]));
          end else begin
            for (int q = 0; q < 4; q++) for (int n = 0; n < 8; n++)
              b_m[4*(cnt-4)+q][n] = int'($signed(ld_data[(q*8+n)*8 +: 8]));
          end
          ld_taken = 1;
          cnt++;
          if (cnt == 8) begin cnt = 0; ph = 2; end
        end
        2: begin
          cnt++;
          if (cnt == 4) begin
            for (int r = 0; r < 8; r++) for (int n = 0; n < 8; n++)
              for (int k = 0; k < 16; k++) acc_m[r][n] += a_m[r][k] * b_m[k][n];
            cnt = 0; kc++;
            ph = (kc == kmax) ? 3 : 1;
          end
        end
        default: if (st_ready) begin
          cnt++;
          if (cnt == (wide_m ? 8 : 4)) begin
            cnt = 0; ph = 0; exp_done = 1; tiles_done++;
          end
        end
      endcase
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (checking) begin
      chk(ld_ready === (ph == 1), (ph == 2) ? "R4 ld_ready" : {tag, " R2 ld_ready"},
          256'(ld_ready), 256'(ph == 1));
      chk(st_valid === (ph == 3), {tag, " st_valid"}, 256'(st_valid), 256'(ph == 3));
      chk(done === exp_done, "R9 done", 256'(done), 256'(exp_done));
      if (ph == 3)
        chk(st_data === exp_beat(cnt, wide_m),
            st_ready ? {tag, " R3 st_data"} : {tag, " R8 held st_data"},
            st_data, exp_beat(cnt, wide_m));
    end
  end

  // input driver, 1 ns after each rising edge
  initial begin
    ld_valid = 0; st_ready = 0; ld_data = '0;
    forever begin
      @(posedge clk); #1;
      if (ld_taken) pending = 0;
      if (!pending) begin
        pend_idx = gen_idx; gen_idx = (gen_idx + 1) % 8;
        ld_data = gen_beat(pend_idx, pat); pend_pat = pat; pending = 1;
      end else if (pend_pat != pat) begin
        ld_data = gen_beat(pend_idx, pat); pend_pat = pat;
      end
      ld_valid = hs_full ? 1'b1 : ($urandom_range(0, 3) != 0);
      st_ready = hs_full ? 1'b1 : ($urandom_range(0, 2) != 0);
    end
  end

  task automatic run_tile(int k, bit w, int p, bit full, bit mid, string t);
    int target;
    target = tiles_done + 1;
    @(posedge clk); #2;
    pat = p; hs_full = full; tag = t;
    @(posedge clk); #2;
    k_steps = 8'(k); out_wide = w; start = 1;
    @(posedge clk); #2;
    start = 0;
    if (mid) begin
      // R10: pulses during load and during compute, with other settings
      repeat (4) @(posedge clk); #2;
      k_steps = 8'd1; out_wide = ~w; start = 1;
      @(posedge clk); #2; start = 0;
      wait (ph == 2); @(posedge clk); #2;
      start = 1; @(posedge clk); #2; start = 0;
    end
    wait (tiles_done == target);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0; k_steps = 0; out_wide = 0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk(ld_ready === 1'b0, "R1 ld_ready after reset", 256'(ld_ready), 256'(0));
    chk(st_valid === 1'b0, "R1 st_valid after reset", 256'(st_valid), 256'(0));
    chk(done === 1'b0, "R1 done after reset", 256'(done), 256'(0));
    checking = 1;
    repeat (3) @(negedge clk);
    run_tile(1, 1'b1, 0, 1'b1, 1'b0, "R6 single step");
    run_tile(3, 1'b1, 0, 1'b0, 1'b0, "R5 R6 stalled");
    run_tile(2, 1'b0, 1, 1'b0, 1'b0, "R7 positive sat");
    run_tile(2, 1'b0, 2, 1'b1, 1'b0, "R7 negative sat");
    run_tile(0, 1'b0, 0, 1'b0, 1'b0, "R5 zero depth R7");
    run_tile(4, 1'b0, 0, 1'b0, 1'b0, "R5 R7 random");
    run_tile(2, 1'b1, 0, 1'b1, 1'b1, "R10 busy start R6");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished (%s)", tag);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule